// File: doc/BRIEF.md
# Clear-on-Access Interrupt Controller

This block gathers condition signals from a set of interrupt sources and folds them into a sticky status register. It also drives one interrupt line, and software watches that line. Each source is configured at build time to latch in one of two ways. In level mode it latches in every cycle its condition is high. In edge mode it latches only on a 0-to-1 transition.

Three registers sit behind a small single-cycle request port:
- a raw view of the live condition levels;
- the sticky status register, which is emptied by any read or any write to it;
- a mask register.

The mask register only decides which latched bits may raise the interrupt line. It never stops a bit from being recorded.

A read request is answered one cycle later with a response strobe and data. The interrupt line comes from a flop, so it follows the status and mask registers with one cycle of delay.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the status register is all zeros, the mask register is all ones, and both `irq` and `rsp_valid` are low.
- R2: A read of address 0 (raw view) returns the value of `cond_i` in the request cycle, with no latching.
- R3: Source i with `EDGE_SEL[i]`=0 sets status bit i in every cycle its condition is high. Source i with `EDGE_SEL[i]`=1 sets it only when its condition was low in the previous cycle and is high now. A set bit stays set until a clear. The default `EDGE_SEL` is 8'hF0, so sources 4 to 7 are edge mode.
- R4: A read of address 1 (status) returns the status contents from before the read, and clears all bits.
- R5: A write to address 1 clears all status bits, whatever the write data.
- R6: An event in the same cycle as a clearing access is kept: that bit is set after the clear.
- R7: A write to address 2 loads the mask, and a read of address 2 returns it. A read of address 3 returns zero. Writes to addresses 0 and 3 change no register.
- R8: `irq` is high in the cycle after any cycle in which some status bit is 1 and its mask bit is 0. Otherwise it is low.
- R9: A mask bit of 1 does not stop the matching status bit from being set.
- R10: `rsp_valid` is high exactly in the cycle after a read request, and `rsp_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | N_SRC | Condition level of each interrupt source |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | 0 raw, 1 status, 2 mask, 3 reserved |
| req_wdata | input | N_SRC | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | N_SRC | Read response data |
| irq | output | 1 | Interrupt line |

## Verification
Two functions can fall in the same cycle: a new event being latched, and the status register being cleared by a read or a write. The directed cases provoke this by raising a level source, and by creating a fresh rising edge on an edge-mode source, in the same cycle as a status access. The random phase also produces many such overlaps. The bench judges the result by its reference model: the read returns the contents from before the clear, and the next status read shows only the events of the clearing cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_RAW  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
        logic     clr_stat;
        logic     wr_mask;
    } access_t;

    function automatic access_t decode_access(input logic valid,
                                              input logic write,
                                              input logic [ADDR_W-1:0] addr);
        access_t a;
        a.rd       = valid && !write;
        a.wr       = valid && write;
        a.sel      = reg_sel_e'(addr);
        a.clr_stat = valid && (reg_sel_e'(addr) == SEL_STAT);
        a.wr_mask  = valid && write && (reg_sel_e'(addr) == SEL_MASK);
        return a;
    endfunction

endpackage

// File: rtl/irq_evt_detect.sv
module irq_evt_detect #(
    parameter int          N_SRC    = 8,
    parameter logic [N_SRC-1:0] EDGE_SEL = 8'hF0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] cond_i,
    output logic [N_SRC-1:0] evt_o
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (EDGE_SEL[i]) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= cond_i[i];
            end
            assign evt_o[i] = cond_i[i] && !prev_q;
        end else begin : g_level
            assign evt_o[i] = cond_i[i];
        end
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             clr_i,
    output logic [N_SRC-1:0] status_o
);
    logic [N_SRC-1:0] status_q;
    logic [N_SRC-1:0] status_d;

    always_comb begin
        if (clr_i) status_d = evt_i;
        else       status_d = status_q | evt_i;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    assign status_o = status_q;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  access_t          acc_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic [N_SRC-1:0] cond_i,
    input  logic [N_SRC-1:0] status_i,
    output logic [N_SRC-1:0] mask_o,
    output logic             rvalid_o,
    output logic [N_SRC-1:0] rdata_o,
    output logic             irq_o
);
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] rd_mux;
    logic             rvalid_q;
    logic [N_SRC-1:0] rdata_q;
    logic             irq_q;

    always_comb begin
        unique case (acc_i.sel)
            SEL_RAW:  rd_mux = cond_i;
            SEL_STAT: rd_mux = status_i;
            SEL_MASK: rd_mux = mask_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '1;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (acc_i.wr_mask) mask_q <= wdata_i;
            rvalid_q <= acc_i.rd;
            if (acc_i.rd) rdata_q <= rd_mux;
            irq_q <= |(status_i & ~mask_q);
        end
    end

    assign mask_o   = mask_q;
    assign rvalid_o = rvalid_q;
    assign rdata_o  = rdata_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int               N_SRC    = 8,
    parameter logic [N_SRC-1:0] EDGE_SEL = 8'hF0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] cond_i,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_addr,
    input  logic [N_SRC-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [N_SRC-1:0] rsp_rdata,
    output logic             irq
);
    access_t          acc;
    logic [N_SRC-1:0] evt_w;
    logic [N_SRC-1:0] status_w;
    logic [N_SRC-1:0] mask_w;

    assign acc = decode_access(req_valid, req_write, req_addr);

    irq_evt_detect #(.N_SRC(N_SRC), .EDGE_SEL(EDGE_SEL)) u_det (
        .clk    (clk),
        .rst    (rst),
        .cond_i (cond_i),
        .evt_o  (evt_w)
    );

    irq_status_bank #(.N_SRC(N_SRC)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_w),
        .clr_i    (acc.clr_stat),
        .status_o (status_w)
    );

    irq_regfile #(.N_SRC(N_SRC)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .acc_i    (acc),
        .wdata_i  (req_wdata),
        .cond_i   (cond_i),
        .status_i (status_w),
        .mask_o   (mask_w),
        .rvalid_o (rsp_valid),
        .rdata_o  (rsp_rdata),
        .irq_o    (irq)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       req_addr,
    input logic [N_SRC-1:0] evt,
    input logic [N_SRC-1:0] status_q,
    input logic [N_SRC-1:0] mask_q,
    input logic             irq,
    input logic             rsp_valid
);
    logic clr;
    assign clr = req_valid && (req_addr == 2'd1);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (mask_q == '1 && status_q == '0 && !irq && !rsp_valid));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((status_q & $past(status_q)) == $past(status_q)));

    p_clear_keeps_evt_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (status_q == $past(evt)));

    p_latch_masked_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(evt)) == $past(evt)));

    p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == |($past(status_q) & ~$past(mask_q))));

    p_rsp_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rsp_valid == $past(req_valid && !req_write)));
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .evt       (evt_w),
    .status_q  (status_w),
    .mask_q    (mask_w),
    .irq       (irq),
    .rsp_valid (rsp_valid)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
    localparam int         N       = 8;
    localparam logic [N-1:0] EDGES = 8'hF0;
    localparam time        CLK_P   = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] cond_i = '0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [1:0]   req_addr = '0;
    logic [N-1:0] req_wdata = '0;
    logic         rsp_valid;
    logic [N-1:0] rsp_rdata;
    logic         irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [N-1:0] m_stat = '0;
    logic [N-1:0] m_mask = '1;
    logic [N-1:0] m_prev = '0;

    always #(CLK_P/2) clk = ~clk;

    irq_ctrl #(.N_SRC(N), .EDGE_SEL(EDGES)) u0 (
        .clk(clk), .rst(rst), .cond_i(cond_i),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq(irq)
    );

    function automatic logic [N-1:0] f_events(input logic [N-1:0] c, input logic [N-1:0] p);
        return (c & ~EDGES) | (c & ~p & EDGES);
    endfunction

    function automatic string f_tag(input logic [1:0] a);
        case (a)
            2'd0: return "R2";
            2'd1: return "R4";
            2'd2: return "R7";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] c, input logic v, input logic w,
                        input logic [1:0] a, input logic [N-1:0] d);
        logic [N-1:0] ev;
        logic         e_irq;
        logic         e_rv;
        logic [N-1:0] e_rd;
        cond_i = c; req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        ev    = f_events(c, m_prev);
        e_irq = |(m_stat & ~m_mask);
        e_rv  = v && !w;
        case (a)
            2'd0: e_rd = c;
            2'd1: e_rd = m_stat;
            2'd2: e_rd = m_mask;
            default: e_rd = '0;
        endcase
        @(posedge clk);
        #1;
        if (v && a == 2'd1) m_stat = ev;
        else                m_stat = m_stat | ev;
        if (v && w && a == 2'd2) m_mask = d;
        m_prev = c;
        check("R8 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, e_irq});
        check("R10 rsp_valid", {{(N-1){1'b0}}, rsp_valid}, {{(N-1){1'b0}}, e_rv});
        if (e_rv) check({f_tag(a), " rdata"}, rsp_rdata, e_rd);
    endtask

    task automatic idle(input logic [N-1:0] c);
        step(c, 1'b0, 1'b0, 2'd0, '0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: state straight after reset
        check("R1 irq", {{(N-1){1'b0}}, irq}, '0);
        check("R1 rsp_valid", {{(N-1){1'b0}}, rsp_valid}, '0);
        step('0, 1'b1, 1'b0, 2'd2, '0);   // R1 mask reads all ones
        check("R1 mask", rsp_rdata, '1);
        step('0, 1'b1, 1'b0, 2'd1, '0);   // R1 status zero
        check("R1 status", rsp_rdata, '0);

        // R9: masked events still latch; R3 level source
        step(8'h01, 1'b0, 1'b0, 2'd0, '0);
        idle('0);
        step('0, 1'b1, 1'b0, 2'd1, '0);
        check("R9 masked latch", rsp_rdata, 8'h01);

        // R3: held edge source latches once only
        step(8'h10, 1'b0, 1'b0, 2'd0, '0);
        step(8'h10, 1'b1, 1'b0, 2'd1, '0);   // clear while held high
        check("R3 edge first", rsp_rdata, 8'h10);
        step(8'h10, 1'b1, 1'b0, 2'd1, '0);
        check("R3 edge no relatch", rsp_rdata, 8'h00);

        // R6: event in clearing cycle survives (level and fresh edge)
        step(8'h02, 1'b0, 1'b0, 2'd0, '0);
        step(8'h24, 1'b1, 1'b0, 2'd1, '0);
        check("R6 read before clear", rsp_rdata, 8'h02);
        step('0, 1'b1, 1'b0, 2'd1, '0);
        check("R6 kept", rsp_rdata, 8'h24);

        // R5: write to status clears whatever the data
        step(8'h08, 1'b0, 1'b0, 2'd0, '0);
        step('0, 1'b1, 1'b1, 2'd1, 8'hFF);
        step('0, 1'b1, 1'b0, 2'd1, '0);
        check("R5 write clear", rsp_rdata, 8'h00);

        // R7: writes to raw and reserved ignored; reserved reads zero
        step('0, 1'b1, 1'b1, 2'd2, 8'h5A);
        step('0, 1'b1, 1'b1, 2'd0, 8'hFF);
        step('0, 1'b1, 1'b1, 2'd3, 8'hFF);
        step('0, 1'b1, 1'b0, 2'd2, '0);
        check("R7 mask kept", rsp_rdata, 8'h5A);
        step('0, 1'b1, 1'b0, 2'd3, '0);
        check("R7 reserved", rsp_rdata, 8'h00);
        step('0, 1'b1, 1'b0, 2'd1, '0);
        check("R7 status untouched", rsp_rdata, 8'h00);

        // R8: unmasked source raises irq, masking drops it
        step(8'h01, 1'b1, 1'b1, 2'd2, 8'hFE);
        idle('0);
        check("R8 irq high", {{(N-1){1'b0}}, irq}, 8'h01);
        step('0, 1'b1, 1'b1, 2'd2, 8'hFF);
        idle('0);
        check("R8 irq masked", {{(N-1){1'b0}}, irq}, 8'h00);
        step('0, 1'b1, 1'b0, 2'd1, '0);

        // random phase: R2 R3 R4 R6 R7 R8 R10 against the model
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] c;
            logic         v;
            c = N'($urandom) & N'($urandom);
            v = ($urandom % 3) == 0;
            step(c, v, 1'($urandom), 2'($urandom), N'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule